// File: doc/BRIEF.md
# Subtract-and-Branch Processor Core

A small multi-cycle processor core whose instruction set has grown out of a single-instruction computer. It knows only four operation classes: subtract (which also serves as the only conditional branch), bitwise AND, shift, and a one-word load or store. Instructions are either one halfword (register operands only) or two halfwords, where the second halfword carries a 16-bit signed immediate or a branch offset. Compare-and-branch has no opcode of its own. A subtract whose 32-bit difference has bit 31 set redirects the program counter. A zero difference never branches.

The core runs a plain fetch-execute loop against one synchronous memory port that serves both instructions and data. The port is word wide and returns read data in the cycle after the request. The core fetches one or two halfwords, decodes them and executes. It then writes a 16 x 32-bit register file, in which register 0 always reads as zero, and moves the program counter on. An inequality test is written as two long subtract-and-branch instructions with swapped operands and the same target.

Top module: `sbr_core`

## Requirements
- R1: While `rst` is high, `mem_rd` and `mem_wr` are low. In the first cycle after `rst` falls, the core issues `mem_rd` with `mem_addr` equal to the word holding `RESET_PC`.
- R2: The first halfword encodes bit 15 = length (0 short, 1 long), bits 14:13 = class (00 subtract, 01 AND, 10 shift, 11 memory), bits 12:9 = rd, bits 8:5 = ra, bits 4:1 = rb and bit 0 = variant. A long instruction adds a second halfword, which is sign-extended to 32 bits. Halfwords are stored little-endian within a word, and a long instruction may straddle two words. Without a branch the PC advances by 2 (short) or 4 (long).
- R3: A short subtract writes ra minus rb to rd, modulo 2^32.
- R4: A long subtract with variant 0 writes ra minus rb to rd. It branches to PC + 2 x extension when bit 31 of that difference is set, and otherwise falls through by 4. A zero difference falls through.
- R5: A long subtract with variant 1 writes extension minus rb to rd. An extension of -1 therefore yields the bitwise NOT of rb.
- R6: A short AND writes ra & rb to rd. A long AND writes ra & extension to rd.
- R7: A shift moves ra by a signed 5-bit amount: extension bits 4:0 when long, rb bits 4:0 when short. A value from 0 to 15 shifts left logically. A value from -16 to -1 shifts right arithmetically by its magnitude.
- R8: A memory instruction addresses the byte address ra + extension and accesses the word that holds it. Variant 0 loads that word into rd, after one idle cycle between request and write-back. Variant 1 stores rb there. `mem_rd` and `mem_wr` are never high together.
- R9: Register 0 reads as zero, and writes to it are discarded.
- R10: Two long subtract-and-branch instructions with swapped operands and a common target reach the target whenever the operands differ, and fall through when they are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | MEM_AW | Word address of the current memory request |
| mem_rd | output | 1 | Read request; data returns on `mem_rdata` in the following cycle |
| mem_wr | output | 1 | Write request of `mem_wdata` to `mem_addr` |
| mem_wdata | output | W | Store data |
| mem_rdata | input | W | Read data from the synchronous memory |

## Verification
The bench builds the core with its defaults: 32-bit data, 16 registers, a 10-bit word address (4 KB) and a reset PC of 0. That space holds the program, a data area at byte 0x800, result slots at 0x900 and a completion word at the top, all of which the 16-bit signed extension can reach from register 0. Mixing short and long instructions pushes long instructions across word boundaries. The directed operands reach the sign-bit edge (0x80000000), equal operands and both ends of the shift range.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [1:0] {
    OP_SUB = 2'b00,
    OP_AND = 2'b01,
    OP_SHF = 2'b10,
    OP_MEM = 2'b11
  } op_e;

  typedef struct packed {
    logic              is_long;
    op_e               op;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
    logic              alt;
  } insn_t;

  typedef enum logic [2:0] {
    S_IF0, S_IF1, S_IF2, S_IF3, S_IF4, S_EX, S_LW1, S_LW2
  } st_e;
endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
  import sbr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [15:0]  hw0,
  input  logic [15:0]  hw1,
  output insn_t        ins,
  output logic [W-1:0] imm
);
  localparam int EXT_W = W - 16;

  always_comb begin
    ins.is_long = hw0[15];
    ins.op      = op_e'(hw0[14:13]);
    ins.rd      = hw0[12:9];
    ins.ra      = hw0[8:5];
    ins.rb      = hw0[4:1];
    ins.alt     = hw0[0];
    imm         = hw0[15] ? {{EXT_W{hw1[15]}}, hw1} : '0;
  end
endmodule

// File: rtl/sbr_regfile.sv
module sbr_regfile #(
  parameter int W    = 32,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [W-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0] raddr_a,
  input  logic [$clog2(NREG)-1:0] raddr_b,
  output logic [W-1:0]            rdata_a,
  output logic [W-1:0]            rdata_b
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sbr_alu.sv
module sbr_alu
  import sbr_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [4:0]   shamt,
  output logic [W-1:0] res,
  output logic         neg
);
  logic [4:0]   mag;
  logic [W-1:0] shl, sra;

  always_comb begin
    mag = 5'(~shamt + 5'd1);
    shl = a << shamt;
    sra = W'($signed(a) >>> mag);
    unique case (op)
      OP_SUB:  res = a - b;
      OP_AND:  res = a & b;
      OP_SHF:  res = shamt[4] ? sra : shl;
      default: res = a + b;
    endcase
    neg = res[W-1];
  end
endmodule

// File: rtl/sbr_core.sv
module sbr_core
  import sbr_pkg::*;
#(
  parameter int W        = 32,
  parameter int MEM_AW   = 10,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [W-1:0]      mem_wdata,
  input  logic [W-1:0]      mem_rdata
);
  localparam int PC_W = MEM_AW + 2;
  localparam int NREG = 1 << REG_AW;

  st_e             st;
  logic [PC_W-1:0] pc, next_pc;
  logic [PC_W-2:0] pc_p2_hw;
  logic [15:0]     hw0, hw1, fetched_hw;
  insn_t           ins;
  logic [W-1:0]    imm, br_off;
  logic [W-1:0]    ra_val, rb_val, op_a, op_b, alu_res, rf_wdata;
  logic [4:0]      shamt;
  logic            alu_neg, take_br, rf_we;

  sbr_decode #(.W(W)) u_dec (
    .hw0 (hw0),
    .hw1 (hw1),
    .ins (ins),
    .imm (imm)
  );

  sbr_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (ins.rd),
    .wdata   (rf_wdata),
    .raddr_a (ins.ra),
    .raddr_b (ins.rb),
    .rdata_a (ra_val),
    .rdata_b (rb_val)
  );

  sbr_alu #(.W(W)) u_alu (
    .op    (ins.op),
    .a     (op_a),
    .b     (op_b),
    .shamt (shamt),
    .res   (alu_res),
    .neg   (alu_neg)
  );

  always_comb begin
    pc_p2_hw   = pc[PC_W-1:1] + 1'b1;
    fetched_hw = ((st == S_IF4) ? pc_p2_hw[0] : pc[1]) ? mem_rdata[31:16] : mem_rdata[15:0];
    op_a       = (ins.op == OP_SUB && ins.is_long && ins.alt) ? imm : ra_val;
    op_b       = ((ins.op == OP_AND && ins.is_long) || ins.op == OP_MEM) ? imm : rb_val;
    shamt      = ins.is_long ? imm[4:0] : rb_val[4:0];
    take_br    = (ins.op == OP_SUB) && ins.is_long && !ins.alt && alu_neg;
    br_off     = {imm[W-2:0], 1'b0};
    next_pc    = take_br ? pc + br_off[PC_W-1:0]
                         : pc + (ins.is_long ? PC_W'(4) : PC_W'(2));
    rf_we      = (st == S_EX && ins.op != OP_MEM) || st == S_LW2;
    rf_wdata   = (st == S_LW2) ? mem_rdata : alu_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IF0;
      pc        <= PC_W'(RESET_PC);
      hw0       <= '0;
      hw1       <= '0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      unique case (st)
        S_IF0: begin
          mem_wr   <= 1'b0;
          mem_rd   <= 1'b1;
          mem_addr <= pc[PC_W-1:2];
          st       <= S_IF1;
        end
        S_IF1: begin
          mem_rd <= 1'b0;
          st     <= S_IF2;
        end
        S_IF2: begin
          hw0 <= fetched_hw;
          hw1 <= '0;
          if (fetched_hw[15]) begin
            mem_rd   <= 1'b1;
            mem_addr <= pc_p2_hw[PC_W-2:1];
            st       <= S_IF3;
          end else begin
            st <= S_EX;
          end
        end
        S_IF3: begin
          mem_rd <= 1'b0;
          st     <= S_IF4;
        end
        S_IF4: begin
          hw1 <= fetched_hw;
          st  <= S_EX;
        end
        S_EX: begin
          pc <= next_pc;
          if (ins.op == OP_MEM) begin
            mem_addr <= alu_res[PC_W-1:2];
            if (ins.alt) begin
              mem_wr    <= 1'b1;
              mem_wdata <= rb_val;
              st        <= S_IF0;
            end else begin
              mem_rd <= 1'b1;
              st     <= S_LW1;
            end
          end else begin
            st <= S_IF0;
          end
        end
        S_LW1: begin
          mem_rd <= 1'b0;
          st     <= S_LW2;
        end
        default: st <= S_IF0;
      endcase
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == S_EX && !take_br) |=> pc == PC_W'($past(pc) + ($past(ins.is_long) ? 3'd4 : 3'd2))); // R2
  AST_SUB_DIFF: assert property (@(posedge clk) disable iff (rst)
    (st == S_EX && ins.op == OP_SUB) |-> (W'(alu_res + op_b) == op_a)); // R3
  AST_ZERO_FALLS: assert property (@(posedge clk) disable iff (rst)
    (st == S_EX && ins.op == OP_SUB && ins.is_long && !ins.alt && alu_res == '0)
      |=> pc == PC_W'($past(pc) + 3'd4)); // R4
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R8
  AST_LOAD_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st == S_LW2) |-> ($past(mem_rd) && !mem_rd)); // R8
endmodule

// File: tb/sim_sbr_core.sv
module sim_sbr_core;
  localparam logic [1:0] O_SUB = 2'b00, O_AND = 2'b01, O_SHF = 2'b10, O_MEM = 2'b11;
  localparam int RES_W = 576;
  localparam int DONE_W = 1023;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  mem_addr;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem [1024];
  int n_tests = 0, n_fail = 0, hp = 0, cycles = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  sbr_core u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_hw(input logic [15:0] v);
    if (hp % 2 == 1) mem[hp / 2][31:16] = v;
    else mem[hp / 2][15:0] = v;
    hp++;
  endtask

  task automatic emit_s(input logic [1:0] op, input logic [3:0] rd, ra, rb);
    put_hw({1'b0, op, rd, ra, rb, 1'b0});
  endtask

  task automatic emit_l(input logic [1:0] op, input logic [3:0] rd, ra, rb,
                        input logic alt, input logic [15:0] ext);
    put_hw({1'b1, op, rd, ra, rb, alt});
    put_hw(ext);
  endtask

  task automatic store(input logic [3:0] src, input int slot);
    emit_l(O_MEM, 4'd0, 4'd0, src, 1'b1, 16'(32'h900 + 4 * slot));
  endtask

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] shf(input logic [31:0] x, input logic [4:0] s);
    int n;
    if (!s[4]) return x << s;
    n = 32 - int'(s);
    return $signed(x) >>> n;
  endfunction

  task automatic build(input logic [15:0] imm, input logic [4:0] amt);
    hp = 0;
    emit_l(O_MEM, 4'd1, 4'd0, 4'd0, 1'b0, 16'h0800);
    emit_l(O_MEM, 4'd2, 4'd0, 4'd0, 1'b0, 16'h0804);
    emit_s(O_SUB, 4'd3, 4'd1, 4'd2);                 store(4'd3, 0);
    emit_s(O_AND, 4'd4, 4'd1, 4'd2);                 store(4'd4, 1);
    emit_l(O_AND, 4'd5, 4'd1, 4'd0, 1'b0, imm);      store(4'd5, 2);
    emit_l(O_SUB, 4'd6, 4'd0, 4'd2, 1'b1, imm);      store(4'd6, 3);
    emit_l(O_SHF, 4'd7, 4'd1, 4'd0, 1'b0, {11'd0, amt}); store(4'd7, 4);
    emit_s(O_SHF, 4'd8, 4'd1, 4'd2);                 store(4'd8, 5);
    emit_l(O_SUB, 4'd10, 4'd0, 4'd0, 1'b1, 16'd1);
    emit_l(O_SUB, 4'd9, 4'd1, 4'd2, 1'b0, 16'd4);
    emit_l(O_SUB, 4'd10, 4'd0, 4'd0, 1'b1, 16'd2);   store(4'd10, 6);
    emit_s(O_SUB, 4'd11, 4'd0, 4'd0);
    emit_l(O_SUB, 4'd12, 4'd1, 4'd2, 1'b0, 16'd6);
    emit_l(O_SUB, 4'd12, 4'd2, 4'd1, 1'b0, 16'd4);
    emit_l(O_SUB, 4'd11, 4'd0, 4'd0, 1'b1, 16'd7);   store(4'd11, 7);
    emit_l(O_SUB, 4'd0, 4'd0, 4'd0, 1'b1, 16'd5);    store(4'd0, 8);
    emit_l(O_SUB, 4'd13, 4'd0, 4'd1, 1'b1, 16'hFFFF); store(4'd13, 9);
    emit_l(O_MEM, 4'd0, 4'd0, 4'd0, 1'b1, 16'h0FFC);
    emit_l(O_SUB, 4'd15, 4'd0, 4'd0, 1'b1, 16'd1);
    emit_l(O_SUB, 4'd14, 4'd0, 4'd15, 1'b0, 16'd0);
  endtask

  task automatic run_case(input logic [31:0] a, b, input logic [15:0] imm, input logic [4:0] amt);
    int waited;
    bit done;
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    build(imm, amt);
    mem[512] = a;
    mem[513] = b;
    repeat (3) @(negedge clk);
    chk("R1 idle in reset", {30'd0, mem_rd, mem_wr}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first fetch", {21'd0, mem_rd, mem_addr}, {21'd0, 1'b1, 10'd0});
    waited = 0;
    done = 0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
      if (mem_wr && mem_addr == 10'(DONE_W)) done = 1;
    end
    chk("R2 mixed-length program reaches end", {31'd0, done}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R3 R8 short sub of loaded words", mem[RES_W + 0], a - b);
    chk("R6 short and", mem[RES_W + 1], a & b);
    chk("R6 long and", mem[RES_W + 2], a & sext(imm));
    chk("R5 immediate minus reg", mem[RES_W + 3], sext(imm) - b);
    chk("R7 long shift", mem[RES_W + 4], shf(a, amt));
    chk("R7 short shift", mem[RES_W + 5], shf(a, b[4:0]));
    chk("R4 branch on negative", mem[RES_W + 6], (a - b) >> 31 != 0 ? 32'd1 : 32'd2);
    chk("R10 inequality pair", mem[RES_W + 7], (a != b) ? 32'd0 : 32'd7);
    chk("R9 r0 stays zero", mem[RES_W + 8], 32'd0);
    chk("R5 not via -1", mem[RES_W + 9], ~a);
  endtask

  initial begin
    void'($urandom(32'd2024));
    run_case(32'd5, 32'd5, 16'hFFFF, 5'd0);
    run_case(32'd0, 32'd1, 16'h00F0, 5'd15);
    run_case(32'h8000_0000, 32'd0, 16'h8001, 5'h10);
    run_case(32'hF0F0_1234, 32'h0000_001F, 16'h7FFF, 5'h1F);
    run_case(32'd7, 32'd3, 16'd0, 5'd1);
    for (int k = 0; k < 20; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = (k % 5 == 0) ? ra : $urandom();
      run_case(ra, rb, 16'($urandom()), 5'($urandom()));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule